// File: doc/BRIEF.md
# Holdover Controller with Tracking DAC

This controller governs the holdover behaviour of a clock loop that is locked to an external reference. While the loop is closed it keeps a copy of the digitized loop control word, refreshed on every phase comparison. When the reference is reported invalid and automatic holdover is enabled, the controller opens the loop. It then drives a DAC code that alone sets the oscillator control voltage. That code is either the last tracked control word or a programmed manual code.

The manual code is used in fixed mode. It is also used in tracked mode when the manual-enable bit is set, so the manual setting overrides tracking. Leaving holdover is automatic. Each phase comparison reports an error magnitude, and a counter tallies consecutive comparisons whose error lies strictly below a programmable window. The loop closes again once that tally reaches a programmable hold count. If the two clocks match in frequency but not in phase, the exit can therefore take a long time.

Top module: `holdover_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the controller locked: `loop_open` = 0, `dac_code` = mid-scale (512 for a 10-bit code), `qual_count` = 0, `exit_pulse` = 0.
- R2: While locked, each cycle with `cmp_valid` = 1 captures `ctrl_word` into the tracked register, and `dac_code` shows that value from the next cycle. Cycles without `cmp_valid` leave it unchanged.
- R3: While locked, `ref_valid` = 0 with `cfg_auto_en` = 1 sets `loop_open` on the next cycle. With `cfg_auto_en` = 0, a low `ref_valid` has no effect: the loop stays closed and tracking continues.
- R4: The tracked register freezes on the cycle in which holdover is entered. A control word presented in that cycle is not captured, and the frozen value is again shown on `dac_code` after exit.
- R5: With `cfg_fixed` = 0 (tracked mode) and `cfg_man_en` = 0, the holdover DAC code equals the tracked value held before entry.
- R6: With `cfg_fixed` = 1 (fixed mode), the holdover DAC code equals `cfg_man_code`, sampled on the entry cycle.
- R7: With `cfg_fixed` = 0 and `cfg_man_en` = 1, entering holdover loads `cfg_man_code` rather than the tracked value.
- R8: During holdover, `dac_code` is constant. Later changes to `ctrl_word` or `cfg_man_code` do not alter it.
- R9: In holdover, a comparison with `phase_err < cfg_window` (strict) increments `qual_count`. Any comparison with `phase_err >= cfg_window` resets it to 0, and cycles without `cmp_valid` leave it unchanged. A window of 0 admits no comparison.
- R10: When an in-window comparison brings the count to `cfg_hold_cnt`, the next cycle has `loop_open` = 0, `qual_count` = 0 and a one-cycle `exit_pulse` = 1. A hold count of 0 behaves as 1.
- R11: `qual_count` is 0 in the first holdover cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference present flag |
| cmp_valid | input | 1 | A phase comparison completes this cycle |
| phase_err | input | 8 | Phase-error magnitude of this comparison |
| ctrl_word | input | 10 | Digitized loop control word |
| cfg_auto_en | input | 1 | Enable automatic holdover entry and exit |
| cfg_fixed | input | 1 | 1 = fixed (manual) mode, 0 = tracked mode |
| cfg_man_en | input | 1 | Manual override in tracked mode |
| cfg_man_code | input | 10 | Programmed manual DAC code |
| cfg_window | input | 8 | Phase-error window (strict upper bound) |
| cfg_hold_cnt | input | 14 | Consecutive in-window comparisons needed to exit |
| dac_code | output | 10 | DAC code (tracked value when locked) |
| loop_open | output | 1 | Loop opened, holdover active |
| qual_count | output | 14 | Current consecutive in-window tally |
| exit_pulse | output | 1 | One-cycle flag after automatic exit |

## Verification
The bench presents a new control word on the very cycle the reference drops. A design that failed to freeze the tracker would hold over on that fresh word, and would show it again after exit. It sets the phase error exactly equal to the window, and it uses a window of zero. An inclusive comparison would count these and exit early. It also places idle cycles between qualifying comparisons, where a design that cleared the tally on them would never exit. Finally, it uses a hold count of zero, where a design that compared against zero literally would hang in holdover or wrap the counter. Each of the three code sources is checked, including the manual override in tracked mode, which a design that tested only the mode bit would miss.

// File: rtl/hoc_pkg.sv
package hoc_pkg;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_HOLD   = 1'b1
  } hoc_state_e;

  typedef enum logic {
    SRC_TRACK  = 1'b0,
    SRC_MANUAL = 1'b1
  } hoc_src_e;

  // Manual code wins in fixed mode and whenever the override is set.
  function automatic hoc_src_e pick_source(input logic fixed_mode, input logic man_en);
    return (fixed_mode || man_en) ? SRC_MANUAL : SRC_TRACK;
  endfunction

endpackage

// File: rtl/hoc_tracker.sv
module hoc_tracker #(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [DAC_W-1:0] ctrl_word,
  output logic [DAC_W-1:0] track_code
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      track_code <= MID;
    end else if (upd_en) begin
      track_code <= ctrl_word;
    end
  end
endmodule

// File: rtl/hoc_qualifier.sv
module hoc_qualifier #(
  parameter int WIN_W = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             cmp_valid,
  input  logic [WIN_W-1:0] phase_err,
  input  logic [WIN_W-1:0] window,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] count,
  output logic             in_window,
  output logic             reached
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  function automatic logic inside_window(input logic [WIN_W-1:0] err,
                                         input logic [WIN_W-1:0] win);
    return err < win;
  endfunction

  // True when one more qualifying comparison meets the target; zero acts as one.
  function automatic logic hits_target(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] tgt);
    logic [CNT_W:0] nxt;
    logic [CNT_W:0] eff;
    nxt = {1'b0, cnt} + ONE;
    eff = (tgt == '0) ? ONE : {1'b0, tgt};
    return nxt >= eff;
  endfunction

  assign in_window = inside_window(phase_err, window);
  assign reached   = active && cmp_valid && in_window && hits_target(count, target);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      count <= '0;
    end else if (cmp_valid) begin
      if (!in_window || reached) begin
        count <= '0;
      end else begin
        count <= count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hoc_fsm.sv
module hoc_fsm #(
  parameter int DAC_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_valid,
  input  logic                auto_en,
  input  logic                fixed_mode,
  input  logic                man_en,
  input  logic [DAC_W-1:0]    man_code,
  input  logic [DAC_W-1:0]    track_code,
  input  logic                reached,
  output hoc_pkg::hoc_state_e state_q,
  output logic [DAC_W-1:0]    hold_code,
  output logic                enter_evt,
  output logic                exit_evt,
  output logic                exit_pulse
);
  import hoc_pkg::*;

  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  hoc_src_e src;

  assign src       = pick_source(fixed_mode, man_en);
  assign enter_evt = (state_q == ST_LOCKED) && !ref_valid && auto_en;
  assign exit_evt  = (state_q == ST_HOLD) && reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_LOCKED;
      hold_code  <= MID;
      exit_pulse <= 1'b0;
    end else begin
      exit_pulse <= exit_evt;
      if (enter_evt) begin
        state_q   <= ST_HOLD;
        hold_code <= (src == SRC_MANUAL) ? man_code : track_code;
      end else if (exit_evt) begin
        state_q <= ST_LOCKED;
      end
    end
  end
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl #(
  parameter int DAC_W = 10,
  parameter int WIN_W = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic             cmp_valid,
  input  logic [WIN_W-1:0] phase_err,
  input  logic [DAC_W-1:0] ctrl_word,
  input  logic             cfg_auto_en,
  input  logic             cfg_fixed,
  input  logic             cfg_man_en,
  input  logic [DAC_W-1:0] cfg_man_code,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [CNT_W-1:0] cfg_hold_cnt,
  output logic [DAC_W-1:0] dac_code,
  output logic             loop_open,
  output logic [CNT_W-1:0] qual_count,
  output logic             exit_pulse
);
  import hoc_pkg::*;

  hoc_state_e       state_q;
  logic [DAC_W-1:0] track_code;
  logic [DAC_W-1:0] hold_code;
  logic             enter_evt;
  logic             exit_evt;
  logic             track_upd;
  logic             in_window;
  logic             reached;
  logic             holding;

  assign holding   = (state_q == ST_HOLD);
  // Tracking stops on the entry cycle itself so the pre-holdover value is kept.
  assign track_upd = !holding && cmp_valid && !enter_evt;

  hoc_tracker #(.DAC_W(DAC_W)) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (track_upd),
    .ctrl_word  (ctrl_word),
    .track_code (track_code)
  );

  hoc_qualifier #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .active    (holding),
    .cmp_valid (cmp_valid),
    .phase_err (phase_err),
    .window    (cfg_window),
    .target    (cfg_hold_cnt),
    .count     (qual_count),
    .in_window (in_window),
    .reached   (reached)
  );

  hoc_fsm #(.DAC_W(DAC_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ref_valid  (ref_valid),
    .auto_en    (cfg_auto_en),
    .fixed_mode (cfg_fixed),
    .man_en     (cfg_man_en),
    .man_code   (cfg_man_code),
    .track_code (track_code),
    .reached    (reached),
    .state_q    (state_q),
    .hold_code  (hold_code),
    .enter_evt  (enter_evt),
    .exit_evt   (exit_evt),
    .exit_pulse (exit_pulse)
  );

  assign loop_open = holding;
  assign dac_code  = holding ? hold_code : track_code;
endmodule

// File: rtl/hoc_checker.sv
module hoc_checker #(
  parameter int DAC_W = 10,
  parameter int WIN_W = 8,
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_valid,
  input logic             cmp_valid,
  input logic [WIN_W-1:0] phase_err,
  input logic [DAC_W-1:0] ctrl_word,
  input logic             cfg_auto_en,
  input logic [WIN_W-1:0] cfg_window,
  input logic [DAC_W-1:0] dac_code,
  input logic             loop_open,
  input logic [CNT_W-1:0] qual_count,
  input logic             exit_pulse,
  input logic             exit_evt
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!loop_open && qual_count == '0 && dac_code == MID && !exit_pulse));

  p_track_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (!loop_open && cmp_valid && ref_valid) |=> (dac_code == $past(ctrl_word)));

  p_enter_r3: assert property (@(posedge clk) disable iff (rst)
    (!loop_open && !ref_valid && cfg_auto_en) |=> loop_open);

  p_no_auto_r3: assert property (@(posedge clk) disable iff (rst)
    (!loop_open && !cfg_auto_en) |=> !loop_open);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (loop_open && $past(loop_open)) |-> $stable(dac_code));

  p_outside_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (loop_open && cmp_valid && phase_err >= cfg_window) |=> (loop_open && qual_count == '0));

  p_idle_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (loop_open && !cmp_valid) |=> (loop_open && $stable(qual_count)));

  p_exit_r10: assert property (@(posedge clk) disable iff (rst)
    exit_evt |=> (!loop_open && exit_pulse && qual_count == '0));

  p_pulse_shape_r10: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |-> (!loop_open && $past(loop_open)));

  p_entry_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(loop_open) |-> (qual_count == '0));
endmodule

bind holdover_ctrl hoc_checker #(.DAC_W(DAC_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_valid   (ref_valid),
  .cmp_valid   (cmp_valid),
  .phase_err   (phase_err),
  .ctrl_word   (ctrl_word),
  .cfg_auto_en (cfg_auto_en),
  .cfg_window  (cfg_window),
  .dac_code    (dac_code),
  .loop_open   (loop_open),
  .qual_count  (qual_count),
  .exit_pulse  (exit_pulse),
  .exit_evt    (exit_evt)
);

// File: tb/holdover_ctrl_bench.sv
module holdover_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_valid = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [7:0]  phase_err = '0;
  logic [9:0]  ctrl_word = '0;
  logic        cfg_auto_en = 1'b1;
  logic        cfg_fixed = 1'b0;
  logic        cfg_man_en = 1'b0;
  logic [9:0]  cfg_man_code = '0;
  logic [7:0]  cfg_window = 8'd10;
  logic [13:0] cfg_hold_cnt = 14'd3;
  logic [9:0]  dac_code;
  logic        loop_open;
  logic [13:0] qual_count;
  logic        exit_pulse;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  holdover_ctrl u_holdover_ctrl (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .cmp_valid(cmp_valid),
    .phase_err(phase_err), .ctrl_word(ctrl_word), .cfg_auto_en(cfg_auto_en),
    .cfg_fixed(cfg_fixed), .cfg_man_en(cfg_man_en), .cfg_man_code(cfg_man_code),
    .cfg_window(cfg_window), .cfg_hold_cnt(cfg_hold_cnt), .dac_code(dac_code),
    .loop_open(loop_open), .qual_count(qual_count), .exit_pulse(exit_pulse)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Locked: capture one control word with a comparison.
  task automatic track_word(input int w);
    ref_valid = 1'b1; cmp_valid = 1'b1; ctrl_word = 10'(w); phase_err = 8'd200;
    tick();
    cmp_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    check("R1", "loop_open", int'(loop_open), 0);
    check("R1", "dac_code", int'(dac_code), 512);
    check("R1", "qual_count", int'(qual_count), 0);
    check("R1", "exit_pulse", int'(exit_pulse), 0);
  endtask

  task automatic t_track();
    track_word(100);
    check("R2", "dac after capture", int'(dac_code), 100);
    ctrl_word = 10'd200;
    tick();
    check("R2", "dac without cmp", int'(dac_code), 100);
  endtask

  task automatic t_no_auto();
    cfg_auto_en = 1'b0; ref_valid = 1'b0; cmp_valid = 1'b1; ctrl_word = 10'd300;
    tick();
    check("R3", "loop_open auto off", int'(loop_open), 0);
    check("R3", "tracking auto off", int'(dac_code), 300);
    cmp_valid = 1'b0; ref_valid = 1'b1; cfg_auto_en = 1'b1;
  endtask

  task automatic t_tracked_cycle();
    cfg_fixed = 1'b0; cfg_man_en = 1'b0; cfg_man_code = 10'd11;
    cfg_window = 8'd10; cfg_hold_cnt = 14'd3;
    track_word(345);
    ref_valid = 1'b0; cmp_valid = 1'b1; ctrl_word = 10'd777;
    tick();
    check("R3", "loop_open on entry", int'(loop_open), 1);
    check("R5", "tracked hold code", int'(dac_code), 345);
    check("R11", "count on entry", int'(qual_count), 0);
    ctrl_word = 10'd5; cfg_man_code = 10'd6;
    tick(); tick();
    check("R8", "dac stable", int'(dac_code), 345);
    ref_valid = 1'b1; cmp_valid = 1'b1; phase_err = 8'd5;
    tick();
    check("R9", "count after in-window", int'(qual_count), 1);
    phase_err = 8'd10;
    tick();
    check("R9", "err equal window resets", int'(qual_count), 0);
    phase_err = 8'd5;
    tick();
    cmp_valid = 1'b0;
    tick();
    check("R9", "idle keeps count", int'(qual_count), 1);
    cmp_valid = 1'b1; phase_err = 8'd9;
    tick();
    check("R9", "count two", int'(qual_count), 2);
    check("R10", "still open before target", int'(loop_open), 1);
    phase_err = 8'd0;
    tick();
    check("R10", "loop closed", int'(loop_open), 0);
    check("R10", "exit pulse", int'(exit_pulse), 1);
    check("R10", "count cleared", int'(qual_count), 0);
    cmp_valid = 1'b0;
    tick();
    check("R10", "pulse one cycle", int'(exit_pulse), 0);
    check("R4", "frozen value after exit", int'(dac_code), 345);
  endtask

  task automatic t_fixed();
    cfg_fixed = 1'b1; cfg_man_en = 1'b0; cfg_man_code = 10'd42;
    track_word(600);
    ref_valid = 1'b0;
    tick();
    check("R6", "fixed hold code", int'(dac_code), 42);
    ref_valid = 1'b1; cfg_window = 8'd0; cmp_valid = 1'b1; phase_err = 8'd0;
    tick();
    check("R9", "zero window count", int'(qual_count), 0);
    check("R9", "zero window open", int'(loop_open), 1);
    cfg_window = 8'd10; cfg_hold_cnt = 14'd0;
    tick();
    check("R10", "hold count zero exits", int'(loop_open), 0);
    cmp_valid = 1'b0;
    tick();
  endtask

  task automatic t_override();
    cfg_fixed = 1'b0; cfg_man_en = 1'b1; cfg_man_code = 10'd99; cfg_hold_cnt = 14'd1;
    track_word(700);
    ref_valid = 1'b0;
    tick();
    check("R7", "override hold code", int'(dac_code), 99);
    cfg_man_code = 10'd5;
    tick();
    check("R8", "man code change ignored", int'(dac_code), 99);
    ref_valid = 1'b1; cmp_valid = 1'b1; phase_err = 8'd1;
    tick();
    cmp_valid = 1'b0;
    check("R10", "exit after one", int'(loop_open), 0);
    check("R2", "tracked restored", int'(dac_code), 700);
  endtask

  initial begin
    t_reset();
    t_track();
    t_no_auto();
    t_tracked_cycle();
    t_fixed();
    t_override();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule